// File: doc/BRIEF.md
# SPI Receive Flag and Overflow Logic

This block is the receive-side register set of an SPI peripheral as seen from a small CPU bus. A serial shifter outside the block hands over each finished byte on `byteIn` with a one-cycle `byteDone` strobe. The block decides whether to keep that byte, holds the kept byte in a read-only data register, and tracks three status flags: receiver full, overrun and mode fault. One interrupt output carries both receive and error requests.

Flags are cleared by two-step access sequences. A status read that sees a flag set arms its clear. The matching second access then clears the flag: a data read for receiver full and overrun, or a control write for mode fault. Overrun is sticky. A data read that was not armed by a status read showing overrun leaves overrun set. While overrun is set, every incoming byte is thrown away and receiver full cannot rise again, so receive interrupts stop until software services the error.

Register map (`busAddr`): 0 = control (read/write), 1 = status (read-only), 2 = data (read-only), 3 = unused (reads zero). Writes to status, data or address 3 have no effect.

Top module: `spi_rx_flags`

## Requirements
- R1: After reset, control, status and data all read 0 and `irq` is low.
- R2: A `byteDone` pulse while receiver full (status bit 0) and overrun (status bit 1) are both clear sets receiver full on the next cycle, and the data register (address 2) then returns that byte.
- R3: A `byteDone` pulse while receiver full is set and overrun is clear sets overrun and discards the new byte. The data register keeps the earlier byte.
- R4: Receiver full is cleared only by a data read that follows a status read which saw it set. A data read with no such earlier status read leaves it set.
- R5: If overrun becomes set after the status read that armed the receiver-full clear, the following data read clears receiver full and leaves overrun set.
- R6: While overrun is set, completed bytes do not set receiver full and do not change the data register.
- R7: Overrun is cleared by a data read that follows a status read which saw overrun set. The next byte after that is accepted normally.
- R8: An armed clear survives any other register access in between (control writes, reads of address 3, other status reads). Reset clears every armed state.
- R9: `irq` is high exactly when (control bit 0 and receiver full) or (control bit 1 and (overrun or mode fault)). Control bit 1 gates overrun and mode fault together.
- R10: While control bit 2 (mode-fault enable) is 0, `modeFaultIn` pulses never set mode fault (status bit 2).
- R11: With control bit 2 set, a `modeFaultIn` pulse sets mode fault. It is cleared by a control write that follows a status read which saw it set. A control write with no such status read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for the addressed register (combinational) |
| byteDone | input | 1 | One-cycle strobe: shifter finished a byte |
| byteIn | input | DATA_W | Byte from the shifter, valid with `byteDone` |
| modeFaultIn | input | 1 | One-cycle mode-fault event pulse |
| irq | output | 1 | Shared receive/error interrupt request |

## Verification
The assertions assume that `byteDone` and `modeFaultIn` are single-cycle pulses and that a bus access lasts exactly one cycle. They also assume that a data read and a byte completion never fall in the same cycle, because the flag update for that case is defined only by precedence and is not checked. The stimulus issues every bus access, byte strobe and fault pulse as a separate one-cycle operation, so these collisions never happen. The overrun-between-reads case is produced in separate cycles: first the status read, then the byte, then the data read.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  // control register bit positions
  localparam int CTRL_RX_IE    = 0;
  localparam int CTRL_ERR_IE   = 1;
  localparam int CTRL_FAULT_EN = 2;

  // status register bit positions
  localparam int STAT_RX_FULL  = 0;
  localparam int STAT_OVERRUN  = 1;
  localparam int STAT_FAULT    = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic setRx;
    logic clrRx;
    logic setOvr;
    logic clrOvr;
    logic setFault;
    logic clrFault;
    logic wrCtrl;
  } rxStrobe_t;

  // flag state returned from datapath to control
  typedef struct packed {
    logic rxFull;
    logic overrun;
    logic fault;
    logic faultEn;
  } rxFlags_t;

endpackage

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              byteDone,
  input  logic              modeFaultIn,
  input  rxFlags_t          flags,
  output rxStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic statRd;
  logic dataRd;
  logic ctrlWr;

  // armed two-step clears
  logic armRx;
  logic armOvr;
  logic armFault;

  always_comb begin
    statRd = busSel && !busWr && (busAddr == A_STAT);
    dataRd = busSel && !busWr && (busAddr == A_DATA);
    ctrlWr = busSel &&  busWr && (busAddr == A_CTRL);
  end

  // arming: set by a status read that sees the flag, consumed by the second step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armRx    <= 1'b0;
      armOvr   <= 1'b0;
      armFault <= 1'b0;
    end else begin
      if (dataRd)
        armRx <= 1'b0;
      else if (statRd && flags.rxFull)
        armRx <= 1'b1;

      if (dataRd)
        armOvr <= 1'b0;
      else if (statRd && flags.overrun)
        armOvr <= 1'b1;

      if (ctrlWr)
        armFault <= 1'b0;
      else if (statRd && flags.fault)
        armFault <= 1'b1;
    end
  end

  // strobe generation
  always_comb begin
    strobe          = '0;
    strobe.loadData = byteDone && !flags.rxFull && !flags.overrun;
    strobe.setRx    = byteDone && !flags.rxFull && !flags.overrun;
    strobe.setOvr   = byteDone &&  flags.rxFull && !flags.overrun;
    strobe.clrRx    = dataRd && armRx;
    strobe.clrOvr   = dataRd && armOvr;
    strobe.setFault = modeFaultIn && flags.faultEn;
    strobe.clrFault = ctrlWr && armFault;
    strobe.wrCtrl   = ctrlWr;
  end

  // R4: receiver full only falls right after a data read
  p_rx_clear_by_read_r4 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags.rxFull) |-> $past(busSel && !busWr && busAddr == A_DATA));

  // R7: overrun only falls right after a data read
  p_ovr_clear_by_read_r7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags.overrun) |-> $past(busSel && !busWr && busAddr == A_DATA));

  // R11: mode fault only falls right after a control write
  p_fault_clear_by_write_r11 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags.fault) |-> $past(busSel && busWr && busAddr == A_CTRL));

endmodule

// File: rtl/spi_rx_dp.sv
module spi_rx_dp
  import spi_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [DATA_W-1:0] byteIn,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output rxFlags_t          flags,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] statusWord;
  logic              rxFull;
  logic              overrun;
  logic              fault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.wrCtrl)   ctrlReg <= wdata;
      if (strobe.loadData) dataReg <= byteIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      overrun <= 1'b0;
      fault   <= 1'b0;
    end else begin
      if (strobe.setRx)         rxFull  <= 1'b1;
      else if (strobe.clrRx)    rxFull  <= 1'b0;

      if (strobe.setOvr)        overrun <= 1'b1;
      else if (strobe.clrOvr)   overrun <= 1'b0;

      if (strobe.setFault)      fault   <= 1'b1;
      else if (strobe.clrFault) fault   <= 1'b0;
    end
  end

  always_comb begin
    flags.rxFull  = rxFull;
    flags.overrun = overrun;
    flags.fault   = fault;
    flags.faultEn = ctrlReg[CTRL_FAULT_EN];
  end

  always_comb begin
    statusWord               = '0;
    statusWord[STAT_RX_FULL] = rxFull;
    statusWord[STAT_OVERRUN] = overrun;
    statusWord[STAT_FAULT]   = fault;
  end

  always_comb begin
    unique case (rdAddr)
      A_CTRL:  rdata = ctrlReg;
      A_STAT:  rdata = statusWord;
      A_DATA:  rdata = dataReg;
      default: rdata = '0;
    endcase
  end

  always_comb begin
    irq = (ctrlReg[CTRL_RX_IE] && rxFull)
       || (ctrlReg[CTRL_ERR_IE] && (overrun || fault));
  end

  // R5: overrun holds unless the control issues its armed clear
  p_ovr_sticky_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !strobe.clrOvr) |=> overrun);

  // R6: with overrun set the stored byte never changes
  p_data_kept_r6 : assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> $stable(dataReg));

  // R10: fault cannot rise while its enable is off
  p_no_fault_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[CTRL_FAULT_EN] && !fault) |=> !fault);

  // R3: an overrun event leaves the stored byte untouched
  p_overrun_keeps_r3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> $stable(dataReg) && overrun);

endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              modeFaultIn,
  output logic              irq
);

  rxStrobe_t strobe;
  rxFlags_t  flags;

  spi_rx_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .byteDone(byteDone), .modeFaultIn(modeFaultIn),
    .flags(flags), .strobe(strobe)
  );

  spi_rx_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .byteIn(byteIn), .wdata(busWdata),
    .rdAddr(busAddr), .flags(flags), .rdata(busRdata), .irq(irq)
  );

  // R2: an accepted byte raises receiver full next cycle
  p_accept_r2 : assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !flags.rxFull && !flags.overrun) |=> flags.rxFull);

  // R3: a byte on a full receiver raises overrun
  p_overflow_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && flags.rxFull && !flags.overrun) |=> flags.overrun);

  // R6: with overrun set a byte never raises receiver full
  p_no_rx_on_ovr_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && flags.overrun && !flags.rxFull) |=> !flags.rxFull);

endmodule

// File: tb/test_spi_rx_flags.sv
module test_spi_rx_flags;

  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          byteDone = 1'b0;
  logic [DW-1:0] byteIn = '0;
  logic          modeFaultIn = 1'b0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] expQ[$];
  string         tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  spi_rx_flags i_spi_rx_flags (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .byteDone(byteDone), .byteIn(byteIn),
    .modeFaultIn(modeFaultIn), .irq(irq)
  );

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    #5;
    if (rstN && busSel && !busWr) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %h expected none", busRdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s addr=%0d: got %h expected %h", t, busAddr, busRdata, e);
        end
      end
    end
  end

  // driver tasks: entered at a falling edge, occupy one cycle
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic sendByte(input logic [DW-1:0] b);
    byteDone = 1'b1; byteIn = b;
    @(negedge clk);
    byteDone = 1'b0;
  endtask

  task automatic faultPulse();
    modeFaultIn = 1'b1;
    @(negedge clk);
    modeFaultIn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    #5;
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", t, irq, e);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 8'h00, "R1 ctrl");
    rd(1, 8'h00, "R1 status");
    rd(2, 8'h00, "R1 data");
    chkIrq(1'b0, "R1");

    // R2 accept and R4 two-step clear
    wr(0, 8'h01);
    sendByte(8'hA5);
    rd(1, 8'h01, "R2 status");
    chkIrq(1'b1, "R9 rx enabled");
    rd(2, 8'hA5, "R2 data");
    rd(1, 8'h00, "R4 cleared");
    chkIrq(1'b0, "R9 rx cleared");

    // R4 data read without arming
    sendByte(8'h3C);
    rd(2, 8'h3C, "R4 unarmed read");
    rd(1, 8'h01, "R4 still full");
    rd(2, 8'h3C, "R4 armed read");
    rd(1, 8'h00, "R4 now clear");

    // R3 overflow, R7 clear and recovery
    sendByte(8'h11);
    sendByte(8'h22);
    rd(1, 8'h03, "R3 status");
    rd(2, 8'h11, "R3 data kept");
    rd(1, 8'h00, "R7 cleared");
    sendByte(8'h33);
    rd(1, 8'h01, "R7 next accepted");
    rd(2, 8'h33, "R7 next data");
    rd(1, 8'h00, "R7 idle");

    // R5 overrun between status and data read
    sendByte(8'h44);
    rd(1, 8'h01, "R5 arm rx");
    sendByte(8'h55);
    rd(2, 8'h44, "R5 data");
    rd(1, 8'h02, "R5 overrun remains");
    // R6 lost byte
    sendByte(8'h66);
    rd(1, 8'h02, "R6 rx not set");
    chkIrq(1'b0, "R9 err disabled");
    // R8 intervening accesses keep the armed overrun clear
    wr(0, 8'h03);
    chkIrq(1'b1, "R9 err enabled");
    rd(3, 8'h00, "R8 unused addr");
    wr(1, 8'hFF);
    wr(2, 8'hEE);
    rd(2, 8'h44, "R6 data unchanged");
    rd(1, 8'h00, "R8 overrun cleared");
    chkIrq(1'b0, "R9 idle");

    // R10 fault disabled
    faultPulse();
    rd(1, 8'h00, "R10 no fault");
    chkIrq(1'b0, "R10");

    // R11 fault set and clear
    wr(0, 8'h07);
    faultPulse();
    rd(1, 8'h04, "R11 fault set");
    chkIrq(1'b1, "R9 fault irq");
    wr(0, 8'h05);
    rd(1, 8'h00, "R11 fault cleared");
    faultPulse();
    wr(0, 8'h05);
    rd(1, 8'h04, "R11 unarmed write");
    chkIrq(1'b0, "R9 err gate off");
    rd(0, 8'h05, "R11 ctrl value");
    wr(0, 8'h07);
    rd(1, 8'h00, "R11 armed write");

    repeat (2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule